// File: doc/BRIEF.md
# Display Controller Register Window Decoder

This block sits behind a 4 KiB memory-mapped window of a display controller. It splits each bus request among three sub-windows. The first is a 32-byte block of legacy byte-wide registers. The second is eleven 16-bit mode registers, reached through an index/data port. The third is a pair of 32-bit extension registers, and it exists only when `EXT_EN` is set. The extension pair holds a read-only size word and a byte-order register. The byte-order register is written with magic words and drives the held `fb_big_endian` output.

The legacy register file and the mode registers live outside the block.

- **Legacy port:** a one-cycle strobe per byte. A 16-bit legacy write becomes two ordered byte writes, low byte first, so an index register and its data register can be loaded in one access.
- **Mode port:** shows the register index, which is the byte offset halved, together with one 16-bit strobe per access.

Bus data is little-endian.

The request side is valid/ready:
- A request is taken in the cycle both `req_valid` and `req_ready` are high.
- The master holds address, size, write flag and data stable while `req_valid` is high and `req_ready` is low.
- `req_ready` drops only for the first beat of a two-byte legacy access, and for one cycle at most.

The response side has no back-pressure. `rsp_valid` pulses for one cycle, the cycle after each accepted request, with `rsp_rdata`. Writes produce a pulse as well.

Top module: `disp_regwin`

## Requirements
- R1: After reset `fb_big_endian` is 0 (little-endian), `rsp_valid` is 0, `req_ready` is 1, and no legacy or mode strobe is active while `req_valid` is low.
- R2: A 1-byte access at window offset 0x400+k (k in 0..31) drives one `lg_wr` or `lg_rd` strobe with `lg_port`=k. A read returns `lg_rdata` in `rsp_rdata[7:0]` with the upper bits zero, and `req_ready` stays high.
- R3: A 2-byte write at 0x400+k drives, in the first cycle, `lg_wr` with `lg_port`=k and `lg_wdata`=wdata[7:0], with `req_ready` low. In the next cycle it drives `lg_wr` with `lg_port`=k+1 (modulo 32) and `lg_wdata`=wdata[15:8], and the request is taken.
- R4: A 2-byte read at 0x400+k returns port k in `rsp_rdata[7:0]` and port k+1 in `rsp_rdata[15:8]`, with bits 31:16 zero.
- R5: A 4-byte legacy access is narrowed to the 2-byte access of R3/R4 using wdata[15:0]. Port k+2 is not touched.
- R6: An access of any size at offset 0x500+2i+b (i in 0..10, b in 0..1) drives one `mode_wr` or `mode_rd` strobe with `mode_idx`=i and `mode_wdata`=wdata[15:0]. A read returns `mode_rdata` zero-extended.
- R7: When `EXT_EN`=1, a 4-byte read at 0x600 returns 8.
- R8: A 4-byte write of 0xBEBEBEBE at 0x604 sets `fb_big_endian`, and 0x1E1E1E1E clears it; any other value leaves it unchanged. A 4-byte read of 0x604 returns 0xBEBEBEBE when the flag is set and 0x1E1E1E1E when it is clear.
- R9: Accesses to 0x600..0x607 of any size other than 4 bytes change nothing and read as zero.
- R10: Accesses outside 0x400..0x41F, 0x500..0x515 and (with `EXT_EN`) 0x600..0x607 drive no strobe and read as zero.
- R11: `rev_id` equals 2 when `EXT_EN`=1 and `BASE_REV` otherwise.
- R12: `rsp_valid` is high exactly in the cycle after each accepted request, and `req_ready` is never low in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset within the window |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| req_wdata | input | 32 | Write data, little-endian |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Read data, zero for writes |
| lg_wr | output | 1 | Legacy byte write strobe |
| lg_rd | output | 1 | Legacy byte read strobe |
| lg_port | output | 5 | Legacy port number (0 = first of 32 ports) |
| lg_wdata | output | 8 | Legacy write byte |
| lg_rdata | input | 8 | Legacy read byte for lg_port, combinational |
| mode_wr | output | 1 | Mode register write strobe |
| mode_rd | output | 1 | Mode register read strobe |
| mode_idx | output | 4 | Mode register index |
| mode_wdata | output | 16 | Mode register write data |
| mode_rdata | input | 16 | Mode register read data for mode_idx, combinational |
| fb_big_endian | output | 1 | Held framebuffer byte-order flag |
| rev_id | output | 8 | Revision reported for the configured feature set |

## Verification
Two functions can meet in one cycle: the second byte of a split legacy access and the acceptance of the request that carries it. The bench provokes this with 2-byte and 4-byte legacy writes and reads while a stub register file records every strobe with a cycle stamp. It judges the result by checking that the two byte strobes land on consecutive cycles, on consecutive ports and in low-then-high order. It also checks that the response pulse comes exactly one cycle after the second beat and not after the first.

// File: rtl/dispwin_pkg.sv
package dispwin_pkg;
  typedef enum logic [1:0] {
    RG_NONE   = 2'd0,
    RG_LEGACY = 2'd1,
    RG_MODE   = 2'd2,
    RG_EXTN   = 2'd3
  } region_e;

  localparam logic [1:0]  SZ_BYTE = 2'd0;
  localparam logic [1:0]  SZ_WORD = 2'd2;
  localparam logic [31:0] MAGIC_BIG    = 32'hBEBE_BEBE;
  localparam logic [31:0] MAGIC_LITTLE = 32'h1E1E_1E1E;
  localparam int unsigned EXTN_BYTES   = 8;
endpackage

// File: rtl/dw_decode.sv
module dw_decode
  import dispwin_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned LEG_BASE  = 'h400,
  parameter int unsigned LEG_BYTES = 32,
  parameter int unsigned MODE_BASE = 'h500,
  parameter int unsigned MODE_REGS = 11,
  parameter int unsigned EXTN_BASE = 'h600,
  parameter bit          EXT_EN    = 1'b1,
  localparam int unsigned LEG_AW   = $clog2(LEG_BYTES),
  localparam int unsigned MODE_IW  = $clog2(MODE_REGS)
) (
  input  logic [ADDR_W-1:0]  addr,
  output region_e            region,
  output logic [LEG_AW-1:0]  leg_off,
  output logic [MODE_IW-1:0] mode_idx,
  output logic [2:0]         extn_off
);
  logic [31:0] a32, leg_rel, mode_rel, extn_rel;
  logic        leg_hit, mode_hit, extn_hit;

  assign a32      = 32'(addr);
  assign leg_rel  = a32 - LEG_BASE;
  assign mode_rel = a32 - MODE_BASE;
  assign extn_rel = a32 - EXTN_BASE;
  assign leg_hit  = leg_rel < LEG_BYTES;
  assign mode_hit = mode_rel < 2 * MODE_REGS;
  assign extn_hit = EXT_EN && (extn_rel < EXTN_BYTES);

  assign leg_off  = leg_rel[LEG_AW-1:0];
  assign mode_idx = mode_rel[MODE_IW:1];
  assign extn_off = extn_rel[2:0];

  always_comb begin
    if (leg_hit)       region = RG_LEGACY;
    else if (mode_hit) region = RG_MODE;
    else if (extn_hit) region = RG_EXTN;
    else               region = RG_NONE;
  end

  always_comb begin
    assert_single_region_R10: assert ($countones({leg_hit, mode_hit, extn_hit}) <= 1);
  end
endmodule

// File: rtl/dw_legacy_seq.sv
module dw_legacy_seq #(
  parameter int unsigned LEG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              hit,
  input  logic              write,
  input  logic              wide,
  input  logic [LEG_AW-1:0] off,
  input  logic [15:0]       wdata,
  input  logic [7:0]        lg_rdata,
  output logic              stall,
  output logic              beat2,
  output logic              lg_wr,
  output logic              lg_rd,
  output logic [LEG_AW-1:0] lg_port,
  output logic [7:0]        lg_wdata,
  output logic [7:0]        lo_q
);
  logic active;

  assign active   = req_valid && hit;
  assign stall    = active && wide && !beat2;
  assign lg_wr    = active && write;
  assign lg_rd    = active && !write;
  assign lg_port  = beat2 ? off + 1'b1 : off;
  assign lg_wdata = beat2 ? wdata[15:8] : wdata[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat2 <= 1'b0;
      lo_q  <= '0;
    end else begin
      beat2 <= stall;
      if (stall) lo_q <= lg_rdata;
    end
  end

  assert_hi_after_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lg_wr && stall) |=> (lg_wr && lg_port == $past(lg_port) + 1'b1 && !stall));
  assert_split_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lg_rd && stall) |=> (lg_rd && lg_port == $past(lg_port) + 1'b1));
endmodule

// File: rtl/dw_extn.sv
module dw_extn
  import dispwin_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        word_acc,
  input  logic [2:0]  off,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        big
);
  always_ff @(posedge clk) begin
    if (!rst_n) big <= 1'b0;
    else if (wr_en && off == 3'd4) begin
      if (wdata == MAGIC_BIG)         big <= 1'b1;
      else if (wdata == MAGIC_LITTLE) big <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (word_acc) begin
      if (off == 3'd0)      rdata = 32'(EXTN_BYTES);
      else if (off == 3'd4) rdata = big ? MAGIC_BIG : MAGIC_LITTLE;
    end
  end

  assert_order_magic_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(big) |-> ($past(wr_en) &&
                       ($past(wdata) == MAGIC_BIG || $past(wdata) == MAGIC_LITTLE)));
endmodule

// File: rtl/disp_regwin.sv
module disp_regwin
  import dispwin_pkg::*;
#(
  parameter bit          EXT_EN    = 1'b1,
  parameter logic [7:0]  BASE_REV  = 8'd1,
  parameter int unsigned LEG_BASE  = 'h400,
  parameter int unsigned LEG_BYTES = 32,
  parameter int unsigned MODE_BASE = 'h500,
  parameter int unsigned MODE_REGS = 11,
  parameter int unsigned EXTN_BASE = 'h600,
  localparam int unsigned ADDR_W   = 12,
  localparam int unsigned LEG_AW   = $clog2(LEG_BYTES),
  localparam int unsigned MODE_IW  = $clog2(MODE_REGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_size,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic               lg_wr,
  output logic               lg_rd,
  output logic [LEG_AW-1:0]  lg_port,
  output logic [7:0]         lg_wdata,
  input  logic [7:0]         lg_rdata,
  output logic               mode_wr,
  output logic               mode_rd,
  output logic [MODE_IW-1:0] mode_idx,
  output logic [15:0]        mode_wdata,
  input  logic [15:0]        mode_rdata,
  output logic               fb_big_endian,
  output logic [7:0]         rev_id
);
  region_e            region;
  logic [LEG_AW-1:0]  leg_off;
  logic [2:0]         extn_off;
  logic               stall, beat2, accept, word_acc;
  logic [7:0]         lo_q;
  logic [31:0]        extn_rdata, rd_mux;

  dw_decode #(
    .ADDR_W(ADDR_W), .LEG_BASE(LEG_BASE), .LEG_BYTES(LEG_BYTES),
    .MODE_BASE(MODE_BASE), .MODE_REGS(MODE_REGS), .EXTN_BASE(EXTN_BASE),
    .EXT_EN(EXT_EN)
  ) u_dec (
    .addr(req_addr), .region(region), .leg_off(leg_off),
    .mode_idx(mode_idx), .extn_off(extn_off)
  );

  dw_legacy_seq #(.LEG_AW(LEG_AW)) u_leg (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .hit(region == RG_LEGACY), .write(req_write), .wide(req_size != SZ_BYTE),
    .off(leg_off), .wdata(req_wdata[15:0]), .lg_rdata(lg_rdata),
    .stall(stall), .beat2(beat2), .lg_wr(lg_wr), .lg_rd(lg_rd),
    .lg_port(lg_port), .lg_wdata(lg_wdata), .lo_q(lo_q)
  );

  assign req_ready  = !stall;
  assign accept     = req_valid && req_ready;
  assign word_acc   = req_size == SZ_WORD;
  assign mode_wr    = accept && region == RG_MODE && req_write;
  assign mode_rd    = accept && region == RG_MODE && !req_write;
  assign mode_wdata = req_wdata[15:0];
  assign rev_id     = EXT_EN ? 8'd2 : BASE_REV;

  dw_extn u_extn (
    .clk(clk), .rst_n(rst_n),
    .wr_en(accept && region == RG_EXTN && req_write && word_acc),
    .word_acc(word_acc), .off(extn_off), .wdata(req_wdata),
    .rdata(extn_rdata), .big(fb_big_endian)
  );

  always_comb begin
    rd_mux = '0;
    if (!req_write) begin
      unique case (region)
        RG_LEGACY: rd_mux = beat2 ? {16'h0, lg_rdata, lo_q} : {24'h0, lg_rdata};
        RG_MODE:   rd_mux = {16'h0, mode_rdata};
        RG_EXTN:   rd_mux = extn_rdata;
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) rsp_rdata <= rd_mux;
    end
  end

  assert_rsp_follows_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
  assert_no_spurious_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !rsp_valid);
  assert_ready_low_once_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready);
  assert_mode_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr || mode_rd) |-> (32'(mode_idx) < MODE_REGS));
endmodule

// File: tb/disp_regwin_tb.sv
module disp_regwin_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, lg_wr, lg_rd, mode_wr, mode_rd, fb_big_endian;
  logic [31:0] rsp_rdata;
  logic [4:0]  lg_port;
  logic [7:0]  lg_wdata, lg_rdata, rev_id;
  logic [3:0]  mode_idx;
  logic [15:0] mode_wdata, mode_rdata;

  int vectors = 0, miscompares = 0, cyc = 0, nlw = 0, nmw = 0;
  bit done = 0;
  logic [7:0]  leg_mem [32];
  logic [15:0] mode_mem [11];
  logic [4:0]  log_port [64];
  logic [7:0]  log_data [64];
  int          log_cyc  [64];

  always #(PERIOD/2) clk = ~clk;

  disp_regwin u_dut (.*);

  assign lg_rdata   = leg_mem[lg_port];
  assign mode_rdata = (mode_idx < 4'd11) ? mode_mem[mode_idx] : 16'h0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (lg_wr) begin
      leg_mem[lg_port] <= lg_wdata;
      if (nlw < 64) begin
        log_port[nlw] = lg_port; log_data[nlw] = lg_wdata; log_cyc[nlw] = cyc;
      end
      nlw++;
    end
    if (mode_wr) begin
      if (mode_idx < 4'd11) mode_mem[mode_idx] <= mode_wdata;
      nmw++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [11:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd, output int stalls);
    stalls = 0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    #1;
    while (!req_ready) begin
      stalls++;
      @(posedge clk); @(negedge clk); #1;
    end
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk("R12 rsp pulse", 32'(rsp_valid), 32'd1);
    rd = rsp_rdata;
  endtask

  task automatic t_reset();
    chk("R1 fb order", 32'(fb_big_endian), 32'd0);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 ready", 32'(req_ready), 32'd1);
    chk("R1 idle strobes", 32'({lg_wr, lg_rd, mode_wr, mode_rd}), 32'd0);
    chk("R11 rev_id", 32'(rev_id), 32'd2);
  endtask

  task automatic t_leg_byte();
    logic [31:0] rd; int st, n0;
    n0 = nlw;
    access(1, 12'h405, 2'd0, 32'hFFFF_FF5A, rd, st);
    chk("R2 one strobe", 32'(nlw - n0), 32'd1);
    chk("R2 port", 32'(log_port[n0]), 32'h05);
    chk("R2 no stall", 32'(st), 32'd0);
    access(0, 12'h405, 2'd0, 32'h0, rd, st);
    chk("R2 read back", rd, 32'h5A);
    @(negedge clk);
    chk("R12 single pulse", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_leg_word_wr();
    logic [31:0] rd; int st, n0;
    n0 = nlw;
    access(1, 12'h414, 2'd1, 32'h0000_C307, rd, st);
    chk("R3 two strobes", 32'(nlw - n0), 32'd2);
    chk("R3 first port", 32'(log_port[n0]), 32'h14);
    chk("R3 first data low", 32'(log_data[n0]), 32'h07);
    chk("R3 second port", 32'(log_port[n0+1]), 32'h15);
    chk("R3 second data high", 32'(log_data[n0+1]), 32'hC3);
    chk("R3 consecutive", 32'(log_cyc[n0+1] - log_cyc[n0]), 32'd1);
    chk("R3 ready low one cycle", 32'(st), 32'd1);
  endtask

  task automatic t_leg_word_rd();
    logic [31:0] rd; int st;
    access(1, 12'h40A, 2'd0, 32'h11, rd, st);
    access(1, 12'h40B, 2'd0, 32'h22, rd, st);
    access(0, 12'h40A, 2'd1, 32'h0, rd, st);
    chk("R4 combined read", rd, 32'h0000_2211);
    chk("R4 stall", 32'(st), 32'd1);
  endtask

  task automatic t_leg_dword();
    logic [31:0] rd; int st, n0;
    access(1, 12'h412, 2'd0, 32'h77, rd, st);
    n0 = nlw;
    access(1, 12'h410, 2'd2, 32'hDEAD_BEEF, rd, st);
    chk("R5 two byte writes", 32'(nlw - n0), 32'd2);
    access(0, 12'h412, 2'd0, 32'h0, rd, st);
    chk("R5 port+2 untouched", rd, 32'h77);
    access(0, 12'h410, 2'd2, 32'h0, rd, st);
    chk("R5 narrowed read", rd, 32'h0000_BEEF);
  endtask

  task automatic t_mode();
    logic [31:0] rd; int st;
    access(1, 12'h504, 2'd1, 32'h0000_1234, rd, st);
    chk("R6 idx2 stored", 32'(mode_mem[2]), 32'h1234);
    access(1, 12'h515, 2'd2, 32'hFFFF_5678, rd, st);
    access(0, 12'h514, 2'd0, 32'h0, rd, st);
    chk("R6 idx10 narrowed", rd, 32'h0000_5678);
    access(0, 12'h505, 2'd1, 32'h0, rd, st);
    chk("R6 idx2 read", rd, 32'h0000_1234);
  endtask

  task automatic t_extn();
    logic [31:0] rd; int st;
    access(0, 12'h600, 2'd2, 32'h0, rd, st);
    chk("R7 size word", rd, 32'd8);
    access(0, 12'h604, 2'd2, 32'h0, rd, st);
    chk("R8 reads little", rd, 32'h1E1E_1E1E);
    access(1, 12'h604, 2'd2, 32'hBEBE_BEBE, rd, st);
    chk("R8 set big", 32'(fb_big_endian), 32'd1);
    access(0, 12'h604, 2'd2, 32'h0, rd, st);
    chk("R8 reads big", rd, 32'hBEBE_BEBE);
    access(1, 12'h604, 2'd2, 32'h1234_5678, rd, st);
    chk("R8 other value ignored", 32'(fb_big_endian), 32'd1);
    access(1, 12'h604, 2'd2, 32'h1E1E_1E1E, rd, st);
    chk("R8 set little", 32'(fb_big_endian), 32'd0);
  endtask

  task automatic t_extn_size();
    logic [31:0] rd; int st;
    access(1, 12'h604, 2'd1, 32'hBEBE_BEBE, rd, st);
    chk("R9 half write ignored", 32'(fb_big_endian), 32'd0);
    access(0, 12'h600, 2'd0, 32'h0, rd, st);
    chk("R9 byte read zero", rd, 32'h0);
    access(0, 12'h604, 2'd1, 32'h0, rd, st);
    chk("R9 half read zero", rd, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] rd; int st, l0, m0;
    l0 = nlw; m0 = nmw;
    access(1, 12'h3FF, 2'd0, 32'hAA, rd, st);
    access(1, 12'h516, 2'd1, 32'hAAAA, rd, st);
    access(1, 12'h608, 2'd2, 32'hBEBE_BEBE, rd, st);
    chk("R10 no legacy strobe", 32'(nlw - l0), 32'd0);
    chk("R10 no mode strobe", 32'(nmw - m0), 32'd0);
    chk("R10 order unchanged", 32'(fb_big_endian), 32'd0);
    access(0, 12'h100, 2'd2, 32'h0, rd, st);
    chk("R10 read 0x100", rd, 32'h0);
    access(0, 12'h516, 2'd1, 32'h0, rd, st);
    chk("R10 read 0x516", rd, 32'h0);
    access(0, 12'h608, 2'd2, 32'h0, rd, st);
    chk("R10 read 0x608", rd, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) leg_mem[i] = 8'h00;
    for (int i = 0; i < 11; i++) mode_mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_leg_byte();
    t_leg_word_wr();
    t_leg_word_rd();
    t_leg_dword();
    t_mode();
    t_extn();
    t_extn_size();
    t_unmapped();
    finish_run();
  end

  initial begin
    #(PERIOD * 20000);
    miscompares++;
    vectors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule